// File: doc/BRIEF.md
# Bidirectional Pin Cell with Buried Feedback

This cell sits between one package pin and the logic array of a programmable fabric. On the output side, a routing multiplexer picks one of several candidate terms from the nearby logic cells. The chosen term passes through an optional inversion and drives the pad through a three-state driver. A small control multiplexer picks the driver enable: always off, always on, or one of two product terms.

On the input side, the cell returns a value to the array. That value can pass straight through, or it can be held in a storage element. The storage element works either as an edge-triggered register or as a level-sensitive latch. Its clock is chosen from two global clocks or a product-term clock, with a programmable polarity.

The source of the returned value depends on how the pin is used. For a bidirectional pin, the pad level is returned, so a driven pin reads back its own output. For a pin configured as a dedicated output, an internal sum term from the array is returned instead. Through the storage element, this gives the array an extra buried register or logic path.

The whole cell runs on the fabric clock `clk`. The selected pin clock is sampled on each rising edge of `clk`. An edge of the pin clock is therefore seen as a change between two successive samples.

Top module: `iocell_top`

## Requirements
- R1: The driven pad level is taken from `src_terms[route_sel]`. A `route_sel` value at or beyond the number of sources selects 0.
- R2: When `invert` is 1, the driven pad level is the complement of the routed term. When `invert` is 0, the routed term is driven unchanged.
- R3: The driver enable is chosen by `oe_sel` as follows: 2'b00 never drives, 2'b01 always drives, 2'b10 follows `oe_pta`, and 2'b11 follows `oe_ptb`. `pad_en` reports this enable, and the pad is driven only while it is 1.
- R4: When `dedicated_out` is 0, the feedback source is the pad level. A driven pad returns its own output, and an undriven pad returns the level applied from outside.
- R5: When `dedicated_out` is 1, the feedback source is `sum_term`, whatever the pad level.
- R6: With `in_mode` 2'b00 (bypass) or 2'b11 (also bypass), `fb_out` follows the feedback source in the same cycle.
- R7: With `in_mode` 2'b01 (register), the feedback source is captured at a `clk` edge where the active pin-clock level is 1 and was 0 at the previous `clk` edge. `fb_out` shows the stored value and holds it otherwise.
- R8: With `in_mode` 2'b10 (latch), the feedback source is captured at every `clk` edge where the active pin-clock level is 1. The stored value holds while that level is 0.
- R9: The pin clock is chosen by `clk_sel` as follows: 2'b00 `gclk1`, 2'b01 `gclk2`, 2'b10 `pclk`, and 2'b11 a constant 0. The active level is the selected clock XOR `clk_inv`.
- R10: While `rst_n` is 0 at a `clk` edge, the stored value and the sampled pin-clock history are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_terms | input | N_SRC | Candidate output terms from neighbouring logic cells |
| route_sel | input | SEL_W | Routing multiplexer select |
| invert | input | 1 | Output polarity inversion |
| oe_sel | input | 2 | Driver enable source select |
| oe_pta | input | 1 | Enable product term A |
| oe_ptb | input | 1 | Enable product term B |
| pad | inout | 1 | Package pin |
| pad_en | output | 1 | Driver enable currently applied to the pad |
| dedicated_out | input | 1 | Pin used as output only; feedback carries the sum term |
| sum_term | input | 1 | Internal sum term for buried feedback |
| gclk1 | input | 1 | Global clock 1 |
| gclk2 | input | 1 | Global clock 2 |
| pclk | input | 1 | Product-term clock |
| clk_sel | input | 2 | Pin clock source select |
| clk_inv | input | 1 | Pin clock polarity |
| in_mode | input | 2 | Input storage mode: bypass, register, latch |
| fb_out | output | 1 | Value returned to the array |

## Verification
Several properties are checked on every cycle:
- the fixed driver enable codes;
- a polarity flip that turns the driven pad level over;
- pad readback in bypass mode;
- sum-term feedback for a dedicated output in bypass mode;
- the cleared storage value after reset;
- the register holding its value while every clock input is steady.

Other behaviour shows only in the bench's scenarios, which compare against a cycle model:
- capture on the exact active edge;
- latch transparency and hold;
- the clock-select and polarity encodings;
- the routing choice for each index.

// File: rtl/iocell_pkg.sv
// Shared encodings for the pin cell.
// Assumes two-bit select fields for enable, clock source and input mode.
package iocell_pkg;

    typedef enum logic [1:0] {
        OE_OFF = 2'b00,
        OE_ON  = 2'b01,
        OE_PTA = 2'b10,
        OE_PTB = 2'b11
    } oe_sel_e;

    typedef enum logic [1:0] {
        CK_G1   = 2'b00,
        CK_G2   = 2'b01,
        CK_PT   = 2'b10,
        CK_NONE = 2'b11
    } ck_sel_e;

    typedef enum logic [1:0] {
        IN_BYPASS = 2'b00,
        IN_REG    = 2'b01,
        IN_LATCH  = 2'b10,
        IN_BYP2   = 2'b11
    } in_mode_e;

endpackage

// File: rtl/iocell_route.sv
// Output path: routes one candidate term, applies polarity, picks the driver enable.
// Assumes all inputs are settled combinational terms; out-of-range selects give 0.
module iocell_route
    import iocell_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] src_terms,
    input  logic [SEL_W-1:0] route_sel,
    input  logic             invert,
    input  logic [1:0]       oe_sel,
    input  logic             oe_pta,
    input  logic             oe_ptb,
    output logic             drv_val,
    output logic             drv_en
);

    logic [N_SRC-1:0] hit;
    logic             routed;

    // One-hot decode of the routing select.
    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_hit
            assign hit[i] = (route_sel == SEL_W'(i)) & src_terms[i];
        end
    endgenerate

    // Reduce the decoded terms into the routed term.
    always_comb begin
        routed = |hit;
    end

    // Apply the programmable output polarity.
    always_comb begin
        drv_val = routed ^ invert;
    end

    // Choose the driver enable source.
    always_comb begin
        unique case (oe_sel_e'(oe_sel))
            OE_OFF:  drv_en = 1'b0;
            OE_ON:   drv_en = 1'b1;
            OE_PTA:  drv_en = oe_pta;
            default: drv_en = oe_ptb;
        endcase
    end

endmodule

// File: rtl/iocell_clksel.sv
// Pin clock selection: picks a source, applies polarity, samples it on clk.
// Assumes the pin clocks are slower than clk so each level is seen at least once.
module iocell_clksel
    import iocell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gclk1,
    input  logic       gclk2,
    input  logic       pclk,
    input  logic [1:0] clk_sel,
    input  logic       clk_inv,
    output logic       act_lvl,
    output logic       act_rise
);

    logic src;
    logic lvl_q;

    // Select the raw pin clock source.
    always_comb begin
        unique case (ck_sel_e'(clk_sel))
            CK_G1:   src = gclk1;
            CK_G2:   src = gclk2;
            CK_PT:   src = pclk;
            default: src = 1'b0;
        endcase
    end

    // Apply clock polarity to get the active level.
    always_comb begin
        act_lvl = src ^ clk_inv;
    end

    // Remember the active level seen at the previous clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= act_lvl;
        end
    end

    // An active edge is a 0-to-1 change between two samples.
    always_comb begin
        act_rise = act_lvl & ~lvl_q;
    end

endmodule

// File: rtl/iocell_store.sv
// Input storage: bypass, edge-register or level-latch of the feedback source.
// Assumes act_lvl and act_rise come from the clock selector in the same cycle.
module iocell_store
    import iocell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] in_mode,
    input  logic       d,
    input  logic       act_lvl,
    input  logic       act_rise,
    output logic       q
);

    logic st;

    // Update the stored value according to the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= 1'b0;
        end else begin
            unique case (in_mode_e'(in_mode))
                IN_REG:   if (act_rise) st <= d;
                IN_LATCH: if (act_lvl)  st <= d;
                default:  st <= st;
            endcase
        end
    end

    // Present either the stored value or the live source.
    always_comb begin
        unique case (in_mode_e'(in_mode))
            IN_REG, IN_LATCH: q = st;
            default:          q = d;
        endcase
    end

endmodule

// File: rtl/iocell_top.sv
// Bidirectional pin cell: routed, polarity-controlled three-state output and
// an input feedback path that returns the pad level or, for a dedicated output,
// an internal sum term through optional storage.
// Assumes a synchronous active-low reset on clk.
module iocell_top #(
    parameter int N_SRC = 4,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_terms,
    input  logic [SEL_W-1:0] route_sel,
    input  logic             invert,
    input  logic [1:0]       oe_sel,
    input  logic             oe_pta,
    input  logic             oe_ptb,
    inout  wire              pad,
    output logic             pad_en,
    input  logic             dedicated_out,
    input  logic             sum_term,
    input  logic             gclk1,
    input  logic             gclk2,
    input  logic             pclk,
    input  logic [1:0]       clk_sel,
    input  logic             clk_inv,
    input  logic [1:0]       in_mode,
    output logic             fb_out
);

    logic drv_val;
    logic drv_en;
    logic fb_src;
    logic act_lvl;
    logic act_rise;

    iocell_route #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_route (
        .src_terms (src_terms),
        .route_sel (route_sel),
        .invert    (invert),
        .oe_sel    (oe_sel),
        .oe_pta    (oe_pta),
        .oe_ptb    (oe_ptb),
        .drv_val   (drv_val),
        .drv_en    (drv_en)
    );

    // Three-state pad driver.
    assign pad = drv_en ? drv_val : 1'bz;

    // Report the applied driver enable.
    always_comb begin
        pad_en = drv_en;
    end

    // Pick the feedback source: pad level or buried sum term.
    always_comb begin
        fb_src = dedicated_out ? sum_term : pad;
    end

    iocell_clksel u_clksel (
        .clk      (clk),
        .rst_n    (rst_n),
        .gclk1    (gclk1),
        .gclk2    (gclk2),
        .pclk     (pclk),
        .clk_sel  (clk_sel),
        .clk_inv  (clk_inv),
        .act_lvl  (act_lvl),
        .act_rise (act_rise)
    );

    iocell_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_mode  (in_mode),
        .d        (fb_src),
        .act_lvl  (act_lvl),
        .act_rise (act_rise),
        .q        (fb_out)
    );

endmodule

// File: rtl/iocell_chk.sv
// Property checker for the pin cell, attached to every instance by bind.
// Assumes the synchronous active-low reset of the cell.
module iocell_chk #(
    parameter int N_SRC = 4,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_terms,
    input logic [SEL_W-1:0] route_sel,
    input logic             invert,
    input logic [1:0]       oe_sel,
    input logic             pad,
    input logic             pad_en,
    input logic             dedicated_out,
    input logic             sum_term,
    input logic             gclk1,
    input logic             gclk2,
    input logic             pclk,
    input logic [1:0]       clk_sel,
    input logic             clk_inv,
    input logic [1:0]       in_mode,
    input logic             fb_out
);

    // R3
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_sel == 2'b00) |-> !pad_en);

    // R3
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_sel == 2'b01) |-> pad_en);

    // R2
    polarity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_en && $past(pad_en) && $past(rst_n) && $stable(src_terms)
         && $stable(route_sel) && !$stable(invert)) |-> (pad != $past(pad)));

    // R4
    pad_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dedicated_out && in_mode == 2'b00 && pad_en) |-> (fb_out == pad));

    // R5
    buried_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dedicated_out && in_mode == 2'b00) |-> (fb_out == sum_term));

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && (in_mode == 2'b01 || in_mode == 2'b10)) |-> (fb_out == 1'b0));

    // R7
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mode == 2'b01 && $past(rst_n) && $stable(in_mode) && $stable(clk_sel)
         && $stable(clk_inv) && $stable(gclk1) && $stable(gclk2) && $stable(pclk))
        |=> (in_mode == 2'b00 || in_mode == 2'b11 || $stable(fb_out)));

endmodule

bind iocell_top iocell_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_terms     (src_terms),
    .route_sel     (route_sel),
    .invert        (invert),
    .oe_sel        (oe_sel),
    .pad           (pad),
    .pad_en        (pad_en),
    .dedicated_out (dedicated_out),
    .sum_term      (sum_term),
    .gclk1         (gclk1),
    .gclk2         (gclk2),
    .pclk          (pclk),
    .clk_sel       (clk_sel),
    .clk_inv       (clk_inv),
    .in_mode       (in_mode),
    .fb_out        (fb_out)
);

// File: tb/test_iocell_top.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// compared against a cycle model written from the requirements.
module test_iocell_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_SRC = 4;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_SRC-1:0] src_terms;
    logic [SEL_W-1:0] route_sel;
    logic             invert;
    logic [1:0]       oe_sel;
    logic             oe_pta, oe_ptb;
    wire              pad;
    logic             pad_en;
    logic             dedicated_out, sum_term;
    logic             gclk1, gclk2, pclk;
    logic [1:0]       clk_sel;
    logic             clk_inv;
    logic [1:0]       in_mode;
    logic             fb_out;

    logic ext_drv, ext_val;
    assign pad = ext_drv ? ext_val : 1'bz;

    int n_chk = 0;
    int n_bad = 0;
    logic m_st = 1'b0;
    logic m_lvlq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iocell_top #(.N_SRC(N_SRC), .SEL_W(SEL_W)) i_iocell_top (
        .clk(clk), .rst_n(rst_n), .src_terms(src_terms), .route_sel(route_sel),
        .invert(invert), .oe_sel(oe_sel), .oe_pta(oe_pta), .oe_ptb(oe_ptb),
        .pad(pad), .pad_en(pad_en), .dedicated_out(dedicated_out),
        .sum_term(sum_term), .gclk1(gclk1), .gclk2(gclk2), .pclk(pclk),
        .clk_sel(clk_sel), .clk_inv(clk_inv), .in_mode(in_mode), .fb_out(fb_out)
    );

    function automatic logic f_en(input logic [1:0] s, input logic a, input logic b);
        case (s)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return a;
            default: return b;
        endcase
    endfunction

    function automatic logic f_term(input logic [N_SRC-1:0] t, input logic [SEL_W-1:0] k);
        if (int'(k) < N_SRC) return t[k];
        return 1'b0;
    endfunction

    function automatic logic f_lvl(input logic [1:0] s, input logic g1, input logic g2,
                                   input logic pc, input logic inv);
        logic c;
        case (s)
            2'b00:   c = g1;
            2'b01:   c = g2;
            2'b10:   c = pc;
            default: c = 1'b0;
        endcase
        return c ^ inv;
    endfunction

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Inputs are already set after a negedge; check, then advance one clk.
    task automatic step(input string tag);
        logic en, val, padv, d, lvl, stored;
        en  = f_en(oe_sel, oe_pta, oe_ptb);
        val = f_term(src_terms, route_sel) ^ invert;
        ext_drv = ~en;
        #1;
        padv = en ? val : ext_val;
        d = dedicated_out ? sum_term : padv;
        stored = (in_mode == 2'b01 || in_mode == 2'b10);
        cmp(tag, "pad_en", pad_en, en);
        if (en) cmp(tag, "pad", pad, val);
        cmp(tag, "fb_out", fb_out, stored ? m_st : d);
        lvl = f_lvl(clk_sel, gclk1, gclk2, pclk, clk_inv);
        @(posedge clk);
        if (!rst_n) begin
            m_st = 1'b0;
            m_lvlq = 1'b0;
        end else begin
            if (in_mode == 2'b01 && lvl && !m_lvlq) m_st = d;
            if (in_mode == 2'b10 && lvl) m_st = d;
            m_lvlq = lvl;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst_n = 0; src_terms = '0; route_sel = '0; invert = 0; oe_sel = 2'b00;
        oe_pta = 0; oe_ptb = 0; dedicated_out = 0; sum_term = 0;
        gclk1 = 0; gclk2 = 0; pclk = 0; clk_sel = 2'b00; clk_inv = 0;
        in_mode = 2'b01; ext_drv = 1; ext_val = 1;
        @(negedge clk);
        // R10: reset state with storage selected
        for (int i = 0; i < 3; i++) step("R10");
        rst_n = 1;
        step("R10");

        // R3: each enable code
        in_mode = 2'b00;
        src_terms = 4'b1111;
        for (int s = 0; s < 4; s++) begin
            for (int ab = 0; ab < 4; ab++) begin
                oe_sel = 2'(s); oe_pta = ab[0]; oe_ptb = ab[1];
                step("R3");
            end
        end

        // R1: each routing index, one-hot and one-cold terms
        oe_sel = 2'b01;
        for (int k = 0; k < N_SRC; k++) begin
            route_sel = SEL_W'(k);
            src_terms = 4'(1 << k);   step("R1");
            src_terms = ~4'(1 << k);  step("R1");
        end

        // R2: polarity both ways
        src_terms = 4'b0101; route_sel = 2'd2;
        invert = 1; step("R2");
        invert = 0; step("R2");
        invert = 1; step("R2");

        // R4: driven pin reads back own output; undriven reads external level
        in_mode = 2'b00; dedicated_out = 0;
        oe_sel = 2'b01; ext_val = 0; step("R4");
        oe_sel = 2'b00; ext_val = 1; step("R4");
        ext_val = 0; step("R4");

        // R5: dedicated output returns sum term, not pad
        dedicated_out = 1; oe_sel = 2'b01; invert = 0; src_terms = 4'b1111;
        sum_term = 0; step("R5");
        sum_term = 1; src_terms = 4'b0000; step("R5");
        in_mode = 2'b11; sum_term = 0; step("R6");

        // R7: register captures only on an active edge
        in_mode = 2'b01; clk_sel = 2'b01; clk_inv = 0; gclk2 = 0;
        sum_term = 1; step("R7");
        gclk2 = 1; step("R7");
        sum_term = 0; step("R7");
        step("R7");
        gclk2 = 0; step("R7");
        gclk2 = 1; step("R7");
        step("R7");
        // R9: falling edge of gclk2 with inversion is the active edge
        clk_inv = 1; sum_term = 1; gclk2 = 1; step("R9");
        gclk2 = 0; step("R9");
        step("R9");

        // R8: latch follows while level active, holds otherwise
        in_mode = 2'b10; clk_sel = 2'b10; clk_inv = 0; pclk = 1;
        sum_term = 0; step("R8");
        sum_term = 1; step("R8");
        step("R8");
        pclk = 0; sum_term = 0; step("R8");
        step("R8");
        // R9: constant-zero source, inverted makes the latch transparent
        clk_sel = 2'b11; clk_inv = 0; sum_term = 1; step("R9");
        step("R9");
        clk_inv = 1; step("R9");
        step("R9");
        sum_term = 0; step("R9");
        step("R9");

        // R10: mid-run reset clears a stored 1
        sum_term = 1; step("R10");
        step("R10");
        rst_n = 0; step("R10");
        rst_n = 1; clk_inv = 0; step("R10");
        step("R10");

        // Random mix of all controls
        for (int n = 0; n < 2000; n++) begin
            rst_n = ($urandom % 64) != 0;
            src_terms = 4'($urandom); route_sel = 2'($urandom);
            invert = 1'($urandom); oe_sel = 2'($urandom);
            oe_pta = 1'($urandom); oe_ptb = 1'($urandom);
            dedicated_out = 1'($urandom); sum_term = 1'($urandom);
            ext_val = 1'($urandom);
            gclk1 = 1'($urandom); gclk2 = 1'($urandom); pclk = 1'($urandom);
            if (($urandom % 8) == 0) clk_sel = 2'($urandom);
            if (($urandom % 16) == 0) clk_inv = 1'($urandom);
            if (($urandom % 8) == 0) in_mode = 2'($urandom);
            step("R1/R2/R7/R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule